// File: doc/BRIEF.md
# Host-to-Coprocessor Mailbox Register Interface

This block places a small register window on the host's I/O bus so that the host and a coprocessor can trade one 16-bit transfer word and one 16-bit status word. The window covers host byte addresses 0xA15000 through 0xA1500F. Every host access that does not land in the window is handed unchanged to a generic I/O request port. A host byte write also goes to that port, even when it targets the window.

The two registers carry a handshake that works in both directions. When the host writes the transfer word, status bit 1 (the "posted" flag) is set and the coprocessor's wait-for-post flag is released. The coprocessor raises status bit 0 (the "reply" flag) through its own port. The host polls the status word, and each such read clears bit 0, which acknowledges the reply.

Host requests use a valid/ready handshake. The host must hold every request field stable while `hreq_valid` is high and `hreq_ready` is low. A window access is never stalled. A forwarded access takes its ready signal from `io_req_ready`. Responses have no back-pressure. A window read answers with `hrsp_valid` exactly one cycle after acceptance. A forwarded read answers whenever the I/O side raises `io_rsp_valid`, and that response passes straight through in the same cycle. The I/O side must not respond in the cycle in which a window read response is due.

Top module: `copro_mailbox`

## Requirements
- R1: A host access outside the window, or any host byte write, appears on the `io_req_*` port with the same write, byte, address and data fields. Its acceptance follows `io_req_ready`. A window access never raises `io_req_valid`, is accepted at once, and a forwarded byte write leaves the transfer word unchanged.
- R2: A host word read at window offset 0x0 or 0x2 returns the transfer word on `hrsp_data`, with `hrsp_valid` high in the cycle after acceptance.
- R3: A host read of the status word (offset 0x4) returns the value from before the access, and then clears status bit 0. A second read therefore shows bit 0 low.
- R4: A host word write at offset 0x0 or 0x2 loads the transfer word, sets status bit 1 and clears `cp_wait`, all visible one cycle after acceptance.
- R5: A host byte read in the window performs the word read of the even address, including the status side effect. An even byte address returns bits 15:8 and an odd byte address returns bits 7:0, both in `hrsp_data[7:0]` with bits 15:8 zero.
- R6: A host word write to any window offset other than 0x0 and 0x2 (for example 0x6) changes neither register nor `cp_wait`.
- R7: A host read at window offsets 0x6 to 0xF returns zero.
- R8: On the coprocessor side, `cp_flag_set` sets status bit 0, `cp_post_clr` clears status bit 1, `cp_wait_set` sets `cp_wait`, `cp_xfer_we` loads the transfer word and `cp_stat_we` loads the whole status word. Each takes effect on the next clock edge.
- R9: When a host access and a coprocessor action hit the same bit in one cycle, the host wins. A status read's clear of bit 0 beats `cp_flag_set`. A transfer write beats `cp_post_clr`, `cp_wait_set` and `cp_xfer_we`.
- R10: After reset the transfer word, the status word and `cp_wait` are zero and `hrsp_valid` is low.
- R11: An I/O response (`io_rsp_valid`, `io_rsp_data`) appears on `hrsp_valid`/`hrsp_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Host request accepted this cycle |
| hreq_write | input | 1 | 1 = write, 0 = read |
| hreq_byte | input | 1 | 1 = byte access, 0 = word access |
| hreq_addr | input | 24 | Host byte address |
| hreq_wdata | input | 16 | Host write data |
| hrsp_valid | output | 1 | Read response valid |
| hrsp_data | output | 16 | Read response data |
| io_req_valid | output | 1 | Forwarded request valid |
| io_req_ready | input | 1 | I/O port accepts request |
| io_req_write | output | 1 | Forwarded write flag |
| io_req_byte | output | 1 | Forwarded byte flag |
| io_req_addr | output | 24 | Forwarded address |
| io_req_wdata | output | 16 | Forwarded write data |
| io_rsp_valid | input | 1 | I/O read response valid |
| io_rsp_data | input | 16 | I/O read response data |
| cp_xfer | output | 16 | Current transfer word |
| cp_xfer_we | input | 1 | Coprocessor loads transfer word |
| cp_xfer_wdata | input | 16 | Coprocessor transfer data |
| cp_stat | output | 16 | Current status word |
| cp_stat_we | input | 1 | Coprocessor loads status word |
| cp_stat_wdata | input | 16 | Coprocessor status data |
| cp_flag_set | input | 1 | Set status bit 0 (reply flag) |
| cp_post_clr | input | 1 | Clear status bit 1 (posted flag) |
| cp_wait_set | input | 1 | Coprocessor begins waiting for a post |
| cp_wait | output | 1 | Coprocessor wait-for-post flag |

## Verification
The bench reads each window read result exactly one cycle after the host request is accepted: it drives inputs on the falling edge and reads the registered response on the next falling edge. Register side effects (status clear, posted flag, wait release, coprocessor pulses) are due on the accepting edge and are checked at the falling edge after it, through `cp_stat`, `cp_xfer`, `cp_wait` or a later host read. Forwarded requests and I/O responses are combinational, so they are checked in the same half-cycle they are driven, before any clock edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    ACC_RD_XFER,
    ACC_RD_STAT,
    ACC_RD_ZERO,
    ACC_WR_XFER,
    ACC_WR_DROP,
    ACC_FWD
  } acc_e;

  // word index inside the window (byte offset >> 1)
  localparam int unsigned XFER_IDX_A = 0;
  localparam int unsigned XFER_IDX_B = 1;
  localparam int unsigned STAT_IDX   = 2;

  // status bit positions
  localparam int unsigned FLAG_BIT = 0;
  localparam int unsigned POST_BIT = 1;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter logic [23:0] WIN_BASE  = 24'hA15000,
  parameter int unsigned WIN_BYTES = 16
) (
  input  logic              is_write,
  input  logic              is_byte,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              kind,
  output logic              fwd
);
  localparam int unsigned WIN_LSB = $clog2(WIN_BYTES);
  localparam int unsigned IDX_W   = WIN_LSB - 1;

  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             idx_xfer;

  assign in_win   = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign idx      = addr[WIN_LSB-1:1];
  assign idx_xfer = (idx == IDX_W'(XFER_IDX_A)) || (idx == IDX_W'(XFER_IDX_B));

  always_comb begin
    if (!in_win || (is_write && is_byte)) begin
      kind = ACC_FWD;
    end else if (is_write) begin
      kind = idx_xfer ? ACC_WR_XFER : ACC_WR_DROP;
    end else if (idx_xfer) begin
      kind = ACC_RD_XFER;
    end else if (idx == IDX_W'(STAT_IDX)) begin
      kind = ACC_RD_STAT;
    end else begin
      kind = ACC_RD_ZERO;
    end
  end

  assign fwd = (kind == ACC_FWD);
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_xfer,
  input  logic              host_rd_stat,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              cp_xfer_we,
  input  logic [DATA_W-1:0] cp_xfer_wdata,
  input  logic              cp_stat_we,
  input  logic [DATA_W-1:0] cp_stat_wdata,
  input  logic              cp_flag_set,
  input  logic              cp_post_clr,
  input  logic              cp_wait_set,
  output logic [DATA_W-1:0] xfer_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              wait_q
);
  logic [DATA_W-1:0] xfer_n, stat_n;
  logic              wait_n;

  // coprocessor actions first, host actions last so the host wins per bit
  always_comb begin
    xfer_n = xfer_q;
    if (cp_xfer_we)   xfer_n = cp_xfer_wdata;
    if (host_wr_xfer) xfer_n = host_wdata;

    stat_n = cp_stat_we ? cp_stat_wdata : stat_q;
    if (cp_flag_set)  stat_n[FLAG_BIT] = 1'b1;
    if (cp_post_clr)  stat_n[POST_BIT] = 1'b0;
    if (host_rd_stat) stat_n[FLAG_BIT] = 1'b0;
    if (host_wr_xfer) stat_n[POST_BIT] = 1'b1;

    wait_n = wait_q;
    if (cp_wait_set)  wait_n = 1'b1;
    if (host_wr_xfer) wait_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= '0;
      stat_q <= '0;
      wait_q <= 1'b0;
    end else begin
      xfer_q <= xfer_n;
      stat_q <= stat_n;
      wait_q <= wait_n;
    end
  end

  // R3
  stat_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_stat |=> !stat_q[FLAG_BIT]);

  // R4
  xfer_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_xfer |=> stat_q[POST_BIT] && !wait_q && (xfer_q == $past(host_wdata)));

  // R8
  cp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_flag_set && !host_rd_stat) |=> stat_q[FLAG_BIT]);

  // R8
  cp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wait_set && !host_wr_xfer) |=> wait_q);
endmodule

// File: rtl/mbx_rdfmt.sv
module mbx_rdfmt
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  acc_e              kind,
  input  logic              is_byte,
  input  logic              odd,
  input  logic [DATA_W-1:0] xfer,
  input  logic [DATA_W-1:0] stat,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] word, shaped;

  always_comb begin
    unique case (kind)
      ACC_RD_XFER: word = xfer;
      ACC_RD_STAT: word = stat;
      default:     word = '0;
    endcase
    if (!is_byte)  shaped = word;
    else if (odd)  shaped = {{HALF{1'b0}}, word[HALF-1:0]};
    else           shaped = {{HALF{1'b0}}, word[DATA_W-1:HALF]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_data <= shaped;
    end
  end

  // R5
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && is_byte) |=> rsp_valid && (rsp_data[DATA_W-1:HALF] == '0));

  // R7
  unused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && kind == ACC_RD_ZERO) |=> (rsp_data == '0));

  // R2
  xfer_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !is_byte && kind == ACC_RD_XFER) |=> (rsp_data == $past(xfer)));
endmodule

// File: rtl/copro_mailbox.sv
module copro_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 16,
  parameter logic [23:0] WIN_BASE  = 24'hA15000,
  parameter int unsigned WIN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hreq_valid,
  output logic              hreq_ready,
  input  logic              hreq_write,
  input  logic              hreq_byte,
  input  logic [ADDR_W-1:0] hreq_addr,
  input  logic [DATA_W-1:0] hreq_wdata,
  output logic              hrsp_valid,
  output logic [DATA_W-1:0] hrsp_data,
  output logic              io_req_valid,
  input  logic              io_req_ready,
  output logic              io_req_write,
  output logic              io_req_byte,
  output logic [ADDR_W-1:0] io_req_addr,
  output logic [DATA_W-1:0] io_req_wdata,
  input  logic              io_rsp_valid,
  input  logic [DATA_W-1:0] io_rsp_data,
  output logic [DATA_W-1:0] cp_xfer,
  input  logic              cp_xfer_we,
  input  logic [DATA_W-1:0] cp_xfer_wdata,
  output logic [DATA_W-1:0] cp_stat,
  input  logic              cp_stat_we,
  input  logic [DATA_W-1:0] cp_stat_wdata,
  input  logic              cp_flag_set,
  input  logic              cp_post_clr,
  input  logic              cp_wait_set,
  output logic              cp_wait
);
  acc_e              kind;
  logic              fwd, accept, win_read;
  logic              win_rsp_valid;
  logic [DATA_W-1:0] win_rsp_data;

  mbx_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
  ) u_dec (
    .is_write(hreq_write), .is_byte(hreq_byte), .addr(hreq_addr),
    .kind(kind), .fwd(fwd)
  );

  assign hreq_ready = fwd ? io_req_ready : 1'b1;
  assign accept     = hreq_valid && hreq_ready;
  assign win_read   = accept && !hreq_write && !fwd;

  assign io_req_valid = hreq_valid && fwd;
  assign io_req_write = hreq_write;
  assign io_req_byte  = hreq_byte;
  assign io_req_addr  = hreq_addr;
  assign io_req_wdata = hreq_wdata;

  mbx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr_xfer(accept && kind == ACC_WR_XFER),
    .host_rd_stat(accept && kind == ACC_RD_STAT),
    .host_wdata(hreq_wdata),
    .cp_xfer_we(cp_xfer_we), .cp_xfer_wdata(cp_xfer_wdata),
    .cp_stat_we(cp_stat_we), .cp_stat_wdata(cp_stat_wdata),
    .cp_flag_set(cp_flag_set), .cp_post_clr(cp_post_clr),
    .cp_wait_set(cp_wait_set),
    .xfer_q(cp_xfer), .stat_q(cp_stat), .wait_q(cp_wait)
  );

  mbx_rdfmt #(.DATA_W(DATA_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .capture(win_read), .kind(kind),
    .is_byte(hreq_byte), .odd(hreq_addr[0]),
    .xfer(cp_xfer), .stat(cp_stat),
    .rsp_valid(win_rsp_valid), .rsp_data(win_rsp_data)
  );

  assign hrsp_valid = win_rsp_valid || io_rsp_valid;
  assign hrsp_data  = win_rsp_valid ? win_rsp_data : io_rsp_data;

  // R1
  window_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_valid && !io_req_valid) |-> hreq_ready);

  // R6
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == ACC_WR_DROP && !cp_xfer_we && !cp_stat_we && !cp_flag_set
     && !cp_post_clr && !cp_wait_set) |=> $stable(cp_xfer) && $stable(cp_stat) && $stable(cp_wait));
endmodule

// File: tb/sim_copro_mailbox.sv
module sim_copro_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq_valid = 0, hreq_write = 0, hreq_byte = 0;
  logic [23:0] hreq_addr = '0;
  logic [15:0] hreq_wdata = '0;
  logic        hreq_ready, hrsp_valid;
  logic [15:0] hrsp_data;
  logic        io_req_valid, io_req_write, io_req_byte;
  logic        io_req_ready = 1'b1;
  logic [23:0] io_req_addr;
  logic [15:0] io_req_wdata;
  logic        io_rsp_valid = 0;
  logic [15:0] io_rsp_data = '0;
  logic [15:0] cp_xfer, cp_stat;
  logic        cp_xfer_we = 0, cp_stat_we = 0;
  logic [15:0] cp_xfer_wdata = '0, cp_stat_wdata = '0;
  logic        cp_flag_set = 0, cp_post_clr = 0, cp_wait_set = 0, cp_wait;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  copro_mailbox u0 (.*);

  // {write, byte, addr[23:0], wdata[15:0], expected[15:0]}
  localparam int NV = 15;
  localparam logic [57:0] VEC [NV] = '{
    {1'b1, 1'b0, 24'hA15000, 16'h1234, 16'h0000},
    {1'b0, 1'b0, 24'hA15000, 16'h0000, 16'h1234},
    {1'b0, 1'b0, 24'hA15002, 16'h0000, 16'h1234},
    {1'b0, 1'b0, 24'hA15004, 16'h0000, 16'h0002},
    {1'b0, 1'b1, 24'hA15000, 16'h0000, 16'h0012},
    {1'b0, 1'b1, 24'hA15001, 16'h0000, 16'h0034},
    {1'b1, 1'b0, 24'hA15006, 16'hFFFF, 16'h0000},
    {1'b0, 1'b0, 24'hA15000, 16'h0000, 16'h1234},
    {1'b0, 1'b0, 24'hA15004, 16'h0000, 16'h0002},
    {1'b0, 1'b0, 24'hA15006, 16'h0000, 16'h0000},
    {1'b0, 1'b0, 24'hA1500E, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 24'hA15002, 16'hABCD, 16'h0000},
    {1'b0, 1'b1, 24'hA15003, 16'h0000, 16'h00CD},
    {1'b0, 1'b1, 24'hA15004, 16'h0000, 16'h0000},
    {1'b0, 1'b1, 24'hA15005, 16'h0000, 16'h0002}
  };

  function automatic string vreq(int i);
    case (i)
      0, 11:         return "R4";
      1, 2, 7:       return "R2";
      3, 8:          return "R3";
      6:             return "R6";
      9, 10:         return "R7";
      default:       return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at a falling edge; rdata is the response
  task automatic host_op(input logic wr, input logic byt, input logic [23:0] a,
                         input logic [15:0] d, output logic [15:0] rdata,
                         output logic rvalid);
    logic ok;
    hreq_valid = 1; hreq_write = wr; hreq_byte = byt; hreq_addr = a; hreq_wdata = d;
    forever begin
      #1 ok = hreq_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    rvalid = hrsp_valid; rdata = hrsp_data;
    hreq_valid = 0;
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        rv;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rsp_valid", 16'(hrsp_valid), 16'h0);
    check("R10 xfer", cp_xfer, 16'h0);
    check("R10 stat", cp_stat, 16'h0);
    check("R10 wait", 16'(cp_wait), 16'h0);
    rst_n = 1;
    cycle();

    for (int i = 0; i < NV; i++) begin
      logic [57:0] v;
      v = VEC[i];
      host_op(v[57], v[56], v[55:32], v[31:16], rd, rv);
      if (!v[57]) begin
        check({vreq(i), " valid"}, 16'(rv), 16'h1);
        check({vreq(i), " data"}, rd, v[15:0]);
      end
    end
    check("R6 xfer after drop", cp_xfer, 16'hABCD);

    // R8 / R3: coprocessor raises reply flag, host polls and acknowledges
    cp_flag_set = 1; cycle(); cp_flag_set = 0;
    check("R8 flag set", cp_stat, 16'h0003);
    host_op(0, 0, 24'hA15004, 0, rd, rv);
    check("R3 poll sees flag", rd, 16'h0003);
    host_op(0, 0, 24'hA15004, 0, rd, rv);
    check("R3 second poll", rd, 16'h0002);
    cp_post_clr = 1; cycle(); cp_post_clr = 0;
    check("R8 post clear", cp_stat, 16'h0000);
    cp_wait_set = 1; cycle(); cp_wait_set = 0;
    check("R8 wait set", 16'(cp_wait), 16'h1);
    host_op(1, 0, 24'hA15000, 16'h5555, rd, rv);
    check("R4 wait released", 16'(cp_wait), 16'h0);
    check("R4 posted", cp_stat, 16'h0002);
    check("R4 xfer", cp_xfer, 16'h5555);
    cp_stat_we = 1; cp_stat_wdata = 16'h8001; cycle(); cp_stat_we = 0;
    host_op(0, 0, 24'hA15004, 0, rd, rv);
    check("R8 stat write", rd, 16'h8001);
    cp_xfer_we = 1; cp_xfer_wdata = 16'h0F0F; cycle(); cp_xfer_we = 0;
    check("R8 xfer write", cp_xfer, 16'h0F0F);

    // R9 same-cycle priority
    cp_flag_set = 1; cycle();
    check("R9 setup", cp_stat, 16'h8001);
    host_op(0, 0, 24'hA15004, 0, rd, rv);
    cp_flag_set = 0;
    check("R9 read old value", rd, 16'h8001);
    check("R9 host clear wins", cp_stat, 16'h8000);
    cp_post_clr = 1; cp_wait_set = 1; cp_xfer_we = 1; cp_xfer_wdata = 16'h1111;
    host_op(1, 0, 24'hA15002, 16'h7777, rd, rv);
    cp_post_clr = 0; cp_wait_set = 0; cp_xfer_we = 0;
    check("R9 post wins", cp_stat, 16'h8002);
    check("R9 wait clear wins", 16'(cp_wait), 16'h0);
    check("R9 host xfer wins", cp_xfer, 16'h7777);

    // R1 forwarding with back-pressure
    io_req_ready = 0;
    hreq_valid = 1; hreq_write = 0; hreq_byte = 0; hreq_addr = 24'hA10002;
    #1;
    check("R1 fwd valid", 16'(io_req_valid), 16'h1);
    check("R1 fwd addr", io_req_addr[15:0], 16'h0002);
    check("R1 stalled", 16'(hreq_ready), 16'h0);
    cycle();
    io_req_ready = 1;
    #1 check("R1 released", 16'(hreq_ready), 16'h1);
    @(posedge clk); @(negedge clk);
    hreq_valid = 0;
    io_rsp_valid = 1; io_rsp_data = 16'hBEEF;
    #1;
    check("R11 rsp valid", 16'(hrsp_valid), 16'h1);
    check("R11 rsp data", hrsp_data, 16'hBEEF);
    cycle();
    io_rsp_valid = 0;
    hreq_valid = 1; hreq_write = 1; hreq_byte = 1; hreq_addr = 24'hA15001; hreq_wdata = 16'h00FF;
    #1;
    check("R1 byte write fwd", {14'h0, io_req_valid, io_req_write}, 16'h0003);
    check("R1 byte write fwd data", io_req_wdata, 16'h00FF);
    @(posedge clk); @(negedge clk);
    hreq_valid = 0;
    check("R1 xfer untouched", cp_xfer, 16'h7777);
    hreq_valid = 1; hreq_write = 0; hreq_byte = 0; hreq_addr = 24'hA15000;
    #1 check("R1 window not forwarded", 16'(io_req_valid), 16'h0);
    hreq_valid = 0;
    cycle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule